// File: doc/BRIEF.md
# Recursive Fibonacci Engine with Continuation Stack

This block returns the Fibonacci number of a small unsigned argument. It does not run a counting loop. It runs the doubly recursive definition directly. Each pending piece of work is written to an on-chip record memory as a tagged continuation. One controller then alternates between two modes. In the evaluate mode it holds an argument and a reference to the continuation awaiting its answer. In the apply mode it holds a value that was just produced and the continuation record fetched to consume it.

There are three record kinds:

- A terminal record ends the run.
- A pending-second-call record remembers the argument whose second recursive call has not yet started.
- A pending-add record remembers the first partial sum.

Every record is consumed exactly once and always in last-in, first-out order. Records are therefore allocated and freed by a single stack pointer. A client pulses `start` with an argument on `arg_n`. It then waits for a one-cycle `done` pulse, after which `result` holds the answer. If the record memory would have to hold more records than it has entries, the engine stops and raises `overflow`.

Top module: `fibk_engine`

## Requirements
- R1: For an argument n of 1 or 2 the result is 1. For larger n it is the sum of the results for n-1 and n-2, taken modulo 2^VAL_W. `done` is high for exactly one cycle, and `result` holds the answer from then until the next run finishes.
- R2: An argument of 0 is treated as a base case and yields 1.
- R3: `busy` is high from the cycle after `start` is accepted until the run ends. A `start` presented while `busy` is high is ignored and does not change the running computation.
- R4: The run has a fixed latency. It evaluates each argument in one cycle and applies each continuation in one cycle. With T(1)=T(2)=T(0)=1 and T(n)=T(n-1)+T(n-2)+3, `done` rises T(n)+2 clock edges after the edge that samples `start`.
- R5: Records are freed when they are loaded, and every load reads the most recently stored live record. After any number of completed runs, an argument needing all DEPTH records still completes.
- R6: A run with argument n needs n-1 records for n of 3 or more. If a store would exceed DEPTH entries, `overflow` rises, `busy` falls, and no `done` pulse is produced.
- R7: Accepting a new `start` clears `overflow` and empties the record stack, so the next run gives the correct result.
- R8: After reset, `busy`, `done`, `overflow` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run with `arg_n`; sampled only when idle |
| arg_n | input | N_W | Unsigned argument n |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | VAL_W | Fibonacci value of the last completed run |
| overflow | output | 1 | Record memory exhausted; run abandoned |

## Verification
The bench builds the engine with DEPTH=16, VAL_W=16 and N_W=6. With a record memory this shallow, the whole range of arguments that fits (0 to 17) can be swept, checking each value and its exact cycle latency. An argument of 17 fills every record entry, and arguments of 18 and above reach the overflow path within a few cycles. The bench follows overflow with a full-depth run, which shows that the stack is reset and that records are reused.

// File: rtl/fibk_pkg.sv
// Package: shared encodings for the continuation-based Fibonacci engine.
// Assumes record tags fit in two bits; value 3 is never written.
package fibk_pkg;

    typedef enum logic [1:0] {
        TAG_DONE = 2'd0,   // terminal continuation
        TAG_SECOND = 2'd1, // holds n, second call pending
        TAG_ADD = 2'd2     // holds first partial sum, addition pending
    } rec_tag_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INIT,
        ST_EVAL,
        ST_APPLY
    } ctl_state_t;

endpackage

// File: rtl/fibk_rec_mem.sv
// Module: continuation record memory. One write port, one read port.
// The read data is registered, so it appears one cycle after the address.
// Assumes the caller never reads an entry in the cycle it writes it.
module fibk_rec_mem #(
    parameter int DEPTH = 256,
    parameter int REC_W = 42,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [REC_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [REC_W-1:0] rdata
);

    logic [REC_W-1:0] store_q [DEPTH];

    // Write a record when requested.
    always_ff @(posedge clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    // Registered read: data follows the address by one cycle.
    always_ff @(posedge clk) begin
        rdata <= store_q[raddr];
    end

endmodule

// File: rtl/fibk_stack_ptr.sv
// Module: allocation pointer for the record memory. It counts live records.
// A push allocates entry `level`; a pop frees the top entry. Clearing
// empties the stack. Assumes push and pop never coincide.
module fibk_stack_ptr #(
    parameter int DEPTH = 256,
    localparam int SPW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           push,
    input  logic           pop,
    output logic [SPW-1:0] level,
    output logic           full
);

    // Track the number of live records.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  level <= '0;
        else if (push)      level <= level + SPW'(1);
        else if (pop)       level <= level - SPW'(1);
    end

    // Full when every entry holds a live record.
    always_comb full = (level == SPW'(DEPTH));

    assert_no_push_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (level != '0));
    assert_push_pop_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/fibk_ctrl.sv
// Module: evaluate/apply controller. In evaluate mode it holds (n, k). In
// apply mode it holds a value and the record fetched from k. It pushes new
// continuations and pops consumed ones.
// Assumes read data arrives one cycle after the read address, and that the
// stack pointer module supplies the live record count.
module fibk_ctrl
    import fibk_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int VAL_W = 32,
    parameter int N_W = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SPW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [N_W-1:0]   arg_n,
    input  logic [SPW-1:0]   level,
    input  logic             full,
    input  logic [1:0]       rd_tag,
    input  logic [VAL_W-1:0] rd_val,
    input  logic [AW-1:0]    rd_parent,
    output logic             sp_clr,
    output logic             push,
    output logic             pop,
    output logic [1:0]       wr_tag,
    output logic [VAL_W-1:0] wr_val,
    output logic [AW-1:0]    wr_parent,
    output logic [AW-1:0]    raddr,
    output logic             busy,
    output logic             done,
    output logic [VAL_W-1:0] result,
    output logic             overflow
);

    ctl_state_t       state_q;
    logic [VAL_W-1:0] arg_q;    // evaluate-mode argument
    logic [VAL_W-1:0] acc_q;    // apply-mode value
    logic [AW-1:0]    kref_q;   // current continuation reference
    rec_tag_t         fetched;
    logic             is_leaf;

    // Decode the fetched record tag and the base-case test.
    always_comb begin
        fetched = rec_tag_t'(rd_tag);
        is_leaf = (arg_q <= VAL_W'(2));
    end

    // Stack, memory and pointer requests for the current mode.
    always_comb begin
        sp_clr    = (state_q == ST_IDLE) && start;
        push      = 1'b0;
        pop       = 1'b0;
        wr_tag    = TAG_DONE;
        wr_val    = '0;
        wr_parent = '0;
        raddr     = kref_q;
        unique case (state_q)
            ST_INIT: push = 1'b1;
            ST_EVAL: begin
                if (!is_leaf && !full) begin
                    push      = 1'b1;
                    wr_tag    = TAG_SECOND;
                    wr_val    = arg_q;
                    wr_parent = kref_q;
                end else if (is_leaf) begin
                    pop = 1'b1;
                end
            end
            ST_APPLY: begin
                if (fetched == TAG_SECOND) begin
                    push      = 1'b1;
                    wr_tag    = TAG_ADD;
                    wr_val    = acc_q;
                    wr_parent = rd_parent;
                end else if (fetched == TAG_ADD) begin
                    pop   = 1'b1;
                    raddr = rd_parent;
                end
            end
            default: ;
        endcase
    end

    // Mode sequencing, argument, value and reference registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            arg_q    <= '0;
            acc_q    <= '0;
            kref_q   <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            result   <= '0;
            overflow <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        arg_q    <= VAL_W'(arg_n);
                        overflow <= 1'b0;
                        busy     <= 1'b1;
                        state_q  <= ST_INIT;
                    end
                end
                ST_INIT: begin
                    kref_q  <= '0;
                    state_q <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (is_leaf) begin
                        acc_q   <= VAL_W'(1);
                        state_q <= ST_APPLY;
                    end else if (full) begin
                        overflow <= 1'b1;
                        busy     <= 1'b0;
                        state_q  <= ST_IDLE;
                    end else begin
                        kref_q <= level[AW-1:0];
                        arg_q  <= arg_q - VAL_W'(1);
                    end
                end
                ST_APPLY: begin
                    unique case (fetched)
                        TAG_DONE: begin
                            result  <= acc_q;
                            done    <= 1'b1;
                            busy    <= 1'b0;
                            state_q <= ST_IDLE;
                        end
                        TAG_SECOND: begin
                            kref_q  <= level[AW-1:0];
                            arg_q   <= rd_val - VAL_W'(2);
                            state_q <= ST_EVAL;
                        end
                        TAG_ADD: acc_q <= rd_val + acc_q;
                        default: begin
                            busy    <= 1'b0;
                            state_q <= ST_IDLE;
                        end
                    endcase
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_load_is_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (SPW'(raddr) == SPW'(level - SPW'(1))));
    assert_tag_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY) |-> (rd_tag != 2'd3));
    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_overflow_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (!busy && !done));
    assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !overflow && $past(busy)) |-> (state_q != ST_IDLE));

endmodule

// File: rtl/fibk_engine.sv
// Module: top of the recursive Fibonacci engine. It connects the controller,
// the allocation pointer and the record memory. A record is packed as
// {tag, value, parent reference}.
// Assumes N_W <= VAL_W and DEPTH >= 2.
module fibk_engine
    import fibk_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int VAL_W = 32,
    parameter int N_W = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SPW = $clog2(DEPTH + 1),
    localparam int REC_W = 2 + VAL_W + AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [N_W-1:0]   arg_n,
    output logic             busy,
    output logic             done,
    output logic [VAL_W-1:0] result,
    output logic             overflow
);

    logic [SPW-1:0]   level;
    logic             full, sp_clr, push, pop;
    logic [1:0]       wr_tag;
    logic [VAL_W-1:0] wr_val;
    logic [AW-1:0]    wr_parent, raddr;
    logic [REC_W-1:0] wdata, rdata;

    // Pack the outgoing record.
    always_comb wdata = {wr_tag, wr_val, wr_parent};

    fibk_ctrl #(.DEPTH(DEPTH), .VAL_W(VAL_W), .N_W(N_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .arg_n     (arg_n),
        .level     (level),
        .full      (full),
        .rd_tag    (rdata[REC_W-1 -: 2]),
        .rd_val    (rdata[AW +: VAL_W]),
        .rd_parent (rdata[AW-1:0]),
        .sp_clr    (sp_clr),
        .push      (push),
        .pop       (pop),
        .wr_tag    (wr_tag),
        .wr_val    (wr_val),
        .wr_parent (wr_parent),
        .raddr     (raddr),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .overflow  (overflow)
    );

    fibk_stack_ptr #(.DEPTH(DEPTH)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sp_clr),
        .push  (push),
        .pop   (pop),
        .level (level),
        .full  (full)
    );

    fibk_rec_mem #(.DEPTH(DEPTH), .REC_W(REC_W)) u_mem (
        .clk   (clk),
        .we    (push),
        .waddr (level[AW-1:0]),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

endmodule

// File: tb/sim_fibk_engine.sv
// Bench: sweeps every argument that fits a 16-entry record memory, checking
// each value and its latency, then exercises overflow, recovery and an
// ignored start.
module sim_fibk_engine;

    localparam int DEPTH = 16;
    localparam int VAL_W = 16;
    localparam int N_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [N_W-1:0]   arg_n = '0;
    logic             busy, done, overflow;
    logic [VAL_W-1:0] result;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    fibk_engine #(.DEPTH(DEPTH), .VAL_W(VAL_W), .N_W(N_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .arg_n(arg_n),
        .busy(busy), .done(done), .result(result), .overflow(overflow)
    );

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint fib_ref(input int n);
        longint a = 1, b = 1, c;
        if (n <= 2) return 1;
        for (int i = 3; i <= n; i++) begin
            c = (a + b) % (64'd1 << VAL_W);
            a = b;
            b = c;
        end
        return b;
    endfunction

    function automatic int lat_ref(input int n);
        int a = 1, b = 1, c;
        if (n <= 2) return 3;
        for (int i = 3; i <= n; i++) begin
            c = a + b + 3;
            a = b;
            b = c;
        end
        return b + 2;
    endfunction

    // Launch one run; count edges after the sampling edge until done or idle.
    task automatic run(input int n, input bit inject, output int lat,
                       output bit got_done, output bit got_busy);
        @(negedge clk);
        arg_n = N_W'(n);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        got_busy = busy;
        lat = 0;
        got_done = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            @(posedge clk);
            lat = lat + 1;
            @(negedge clk);
            if (inject && lat == 5) begin arg_n = N_W'(3); start = 1'b1; end
            if (inject && lat == 7) start = 1'b0;
            if (done) begin got_done = 1'b1; break; end
            if (!busy) break;
        end
    endtask

    initial begin
        int lat;
        bit gd, gb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check("R8 busy", busy, 0);
        check("R8 done", done, 0);
        check("R8 overflow", overflow, 0);
        check("R8 result", result, 0);

        // R1, R2, R4: sweep every argument that fits.
        for (int n = 0; n <= DEPTH + 1; n++) begin
            run(n, 1'b0, lat, gd, gb);
            check(n == 0 ? "R2 base zero" : "R1 value", result, fib_ref(n));
            check("R1 done pulse", gd, 1);
            check("R4 latency", lat, lat_ref(n));
            check("R3 busy after start", gb, 1);
            @(negedge clk);
            check("R1 done one cycle", done, 0);
            check("R1 result held", result, fib_ref(n));
            check("R3 busy drops", busy, 0);
        end

        // R3: start while busy is ignored.
        run(10, 1'b1, lat, gd, gb);
        check("R3 ignored start value", result, fib_ref(10));
        check("R3 ignored start latency", lat, lat_ref(10));
        repeat (3) @(negedge clk);
        check("R3 no second run", busy, 0);

        // R6: overflow just beyond the depth and further beyond it.
        for (int n = DEPTH + 2; n <= DEPTH + 6; n += 4) begin
            run(n, 1'b0, lat, gd, gb);
            check("R6 overflow flag", overflow, 1);
            check("R6 no done", gd, 0);
            check("R6 busy low", busy, 0);
            check("R6 result unchanged", result, fib_ref(10));
        end

        // R7, R5: recovery after overflow, then full depth after many runs.
        run(6, 1'b0, lat, gd, gb);
        check("R7 overflow cleared", overflow, 0);
        check("R7 value after overflow", result, fib_ref(6));
        check("R7 latency after overflow", lat, lat_ref(6));
        run(DEPTH + 1, 1'b0, lat, gd, gb);
        check("R5 full depth reuse", result, fib_ref(DEPTH + 1));
        check("R5 no overflow", overflow, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule